// File: doc/BRIEF.md
# Multiplicative Frequency Boost Controller

This block keeps a frequency boost value that grows or shrinks when an activity monitor reports a run of samples above or below its consecutive watermarks. On an above event the boost is scaled by a programmable percentage and a fixed step is added to it. On a below event it is scaled down by a second percentage. The result is limited to a programmable maximum. When it falls below half a step it collapses to zero. Two enable outputs tell the monitor which of the two consecutive-watermark interrupts stays armed.

The block also computes a target frequency. It divides the average count by the sampling period and multiplies that rate by 10000 over the up threshold. It then divides by 100 and adds the boost. A request strobe or any event starts this calculation. A restart pulse returns the block to its initial state and loads the current frequency as the target.

Top module: `boost_top`

## Requirements
- R1: After reset `boost`=0, `target`=0, `enAbove`=1, `enBelow`=0 and `targetDone`=0. A `restart` pulse gives the same state one cycle later, except that `target` takes the value of `curFreq`. `restart` wins over the events and aborts any calculation in progress.
- R2: An above event (`evtAbove`=1) sets `boost` one cycle later to sat32(old×`upCoeff`/100)+16000 and sets `enBelow`=1. The event is applied whatever the state of the enables.
- R3: If that boosted sum is greater than or equal to `maxFreq`, `boost` becomes `maxFreq` and `enAbove` is cleared. Otherwise `enAbove` keeps its value.
- R4: A below event alone sets `boost` one cycle later to sat32(old×`downCoeff`/100) and sets `enAbove`=1.
- R5: If that reduced value is below 8000, `boost` becomes 0 and `enBelow` is cleared. Otherwise `enBelow` keeps its value. While `enBelow`=0 the boost is 0.
- R6: When both events occur in the same cycle, only the above event is applied.
- R7: Each percentage product, after division by 100, saturates at 2^32−1 (sat32) before any further use.
- R8: A finished calculation pulses `targetDone` for one cycle and, in that same cycle, shows `target` = sat32(sat32((`avgCount`/`periodMs`)×(10000/`upThresh`)/100) + `boost`). Both divisions are integer divisions.
- R9: `calcReq` or either event starts a calculation when the block is idle. A trigger that arrives while a calculation runs causes exactly one more calculation after it, and that calculation uses the inputs present when it starts.
- R10: In a cycle with no event and no restart, `boost` and both enables hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| restart | input | 1 | Reinitialise boost, enables and target |
| evtAbove | input | 1 | Consecutive-above watermark event strobe |
| evtBelow | input | 1 | Consecutive-below watermark event strobe |
| calcReq | input | 1 | Request a target recalculation |
| curFreq | input | 32 | Current frequency, loaded as target on restart |
| avgCount | input | 32 | Average event count for one period |
| periodMs | input | 9 | Sampling period length |
| upThresh | input | 16 | Up threshold percentage |
| upCoeff | input | 16 | Growth percentage |
| downCoeff | input | 16 | Decay percentage |
| maxFreq | input | 32 | Boost ceiling |
| boost | output | 32 | Current boost |
| target | output | 32 | Computed target frequency |
| targetDone | output | 1 | One-cycle pulse when `target` is refreshed |
| enAbove | output | 1 | Arm the consecutive-above interrupt |
| enBelow | output | 1 | Arm the consecutive-below interrupt |

## Verification
Assertions check the following properties on every cycle:
- the ceiling after an above event;
- the arming of the opposite enable;
- the zero-or-at-least-half-step floor after a below event;
- a zero boost whenever `enBelow` is clear;
- the hold behaviour when no event occurs;
- the restart state;
- the single-cycle done pulse of the divider.

Only the bench scenarios can show the following:
- the exact scaled boost values across coefficient sets and event orders;
- product saturation at 2^32−1;
- the target arithmetic, including its saturation;
- the single rerun that follows a trigger arriving during a calculation.

// File: rtl/boost_pkg.sv
package boost_pkg;
  typedef struct packed {
    logic divStart;    // load divider operands
    logic divSel;      // 0: avgCount/periodMs, 1: scale/upThresh
    logic latchFirst;  // capture first quotient
    logic finish;      // form and register the target
  } ctrl_strobe_t;
endpackage

// File: rtl/boost_div.sv
module boost_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic [W-1:0] quo,
  output logic         done
);
  localparam int CNTW = $clog2(W + 1);

  logic [W-1:0]    remR, quoR, denR;
  logic [CNTW-1:0] cntR;
  logic            doneR;
  logic [W:0]      trial;
  logic            fits;

  assign trial = {remR, quoR[W-1]};
  assign fits  = trial >= {1'b0, denR};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remR  <= '0;
      quoR  <= '0;
      denR  <= '0;
      cntR  <= '0;
      doneR <= 1'b0;
    end else begin
      doneR <= 1'b0;
      if (start) begin
        remR <= '0;
        quoR <= num;
        denR <= den;
        cntR <= CNTW'(W);
      end else if (cntR != '0) begin
        remR  <= fits ? W'(trial - {1'b0, denR}) : trial[W-1:0];
        quoR  <= {quoR[W-2:0], fits};
        cntR  <= cntR - 1'b1;
        doneR <= (cntR == CNTW'(1));
      end
    end
  end

  assign quo  = quoR;
  assign done = doneR;

  // R8: completion is a single-cycle pulse, never right after a load
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_no_early_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    start |=> !done);
endmodule

// File: rtl/boost_ctrl.sv
module boost_ctrl
  import boost_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         restart,
  input  logic         trigger,
  input  logic         divDone,
  output ctrl_strobe_t strb
);
  typedef enum logic [1:0] {IDLE, RUN1, RUN2} calc_state_t;

  calc_state_t stR, stNext;
  logic        againR;

  always_comb begin
    strb   = '0;
    stNext = stR;
    if (restart) begin
      stNext = IDLE;
    end else begin
      case (stR)
        IDLE: if (trigger) begin
          strb.divStart = 1'b1;
          stNext        = RUN1;
        end
        RUN1: if (divDone) begin
          strb.latchFirst = 1'b1;
          strb.divStart   = 1'b1;
          strb.divSel     = 1'b1;
          stNext          = RUN2;
        end
        RUN2: if (divDone) begin
          strb.finish = 1'b1;
          if (againR || trigger) begin
            strb.divStart = 1'b1;
            stNext        = RUN1;
          end else begin
            stNext = IDLE;
          end
        end
        default: stNext = IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stR    <= IDLE;
      againR <= 1'b0;
    end else begin
      stR <= stNext;
      if (restart || (stR == RUN2 && divDone)) againR <= 1'b0;
      else if (trigger && stR != IDLE)         againR <= 1'b1;
    end
  end

  // R9: a finished calculation never leaves a rerun flag pending in IDLE
  assert_no_lost_rerun_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stR == IDLE) |-> !againR);
endmodule

// File: rtl/boost_dp.sv
module boost_dp
  import boost_pkg::*;
#(
  parameter int W     = 32,
  parameter int CW    = 16,
  parameter int PW    = 9,
  parameter int STEP  = 16000,
  parameter int PCT   = 100,
  parameter int SCALE = 10000
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          restart,
  input  logic          evtAbove,
  input  logic          evtBelow,
  input  ctrl_strobe_t  strb,
  input  logic [W-1:0]  curFreq,
  input  logic [W-1:0]  avgCount,
  input  logic [PW-1:0] periodMs,
  input  logic [CW-1:0] upThresh,
  input  logic [CW-1:0] upCoeff,
  input  logic [CW-1:0] downCoeff,
  input  logic [W-1:0]  maxFreq,
  output logic [W-1:0]  boost,
  output logic [W-1:0]  target,
  output logic          targetDone,
  output logic          enAbove,
  output logic          enBelow,
  output logic          divDone
);
  localparam logic [W-1:0] HALF = W'(STEP / 2);

  function automatic logic [W-1:0] scalePct(input logic [W-1:0] v, input logic [CW-1:0] c);
    logic [W+CW-1:0] p;
    p = ({{CW{1'b0}}, v} * {{W{1'b0}}, c}) / (W+CW)'(PCT);
    return (|p[W+CW-1:W]) ? '1 : p[W-1:0];
  endfunction

  logic [W-1:0]   boostR, targetR, q1R, divQuo, divNum, divDen, downVal, rate, tgtNext;
  logic           enAboveR, enBelowR, doneR, clampHit, floorHit;
  logic [W:0]     upSum, tSum;
  logic [2*W-1:0] prod, scaled;

  assign divNum = strb.divSel ? W'(SCALE) : avgCount;
  assign divDen = strb.divSel ? W'(upThresh) : W'(periodMs);

  boost_div #(.W(W)) u_div (
    .clk(clk), .rstN(rstN), .start(strb.divStart),
    .num(divNum), .den(divDen), .quo(divQuo), .done(divDone)
  );

  assign upSum    = {1'b0, scalePct(boostR, upCoeff)} + (W+1)'(STEP);
  assign clampHit = upSum >= {1'b0, maxFreq};
  assign downVal  = scalePct(boostR, downCoeff);
  assign floorHit = downVal < HALF;

  assign prod    = {{W{1'b0}}, q1R} * {{W{1'b0}}, divQuo};
  assign scaled  = prod / (2*W)'(PCT);
  assign rate    = (|scaled[2*W-1:W]) ? '1 : scaled[W-1:0];
  assign tSum    = {1'b0, rate} + {1'b0, boostR};
  assign tgtNext = tSum[W] ? '1 : tSum[W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      boostR   <= '0;
      targetR  <= '0;
      q1R      <= '0;
      enAboveR <= 1'b1;
      enBelowR <= 1'b0;
      doneR    <= 1'b0;
    end else if (restart) begin
      boostR   <= '0;
      targetR  <= curFreq;
      enAboveR <= 1'b1;
      enBelowR <= 1'b0;
      doneR    <= 1'b0;
    end else begin
      doneR <= strb.finish;
      if (strb.latchFirst) q1R <= divQuo;
      if (strb.finish) targetR <= tgtNext;
      if (evtAbove) begin
        boostR   <= clampHit ? maxFreq : upSum[W-1:0];
        enBelowR <= 1'b1;
        if (clampHit) enAboveR <= 1'b0;
      end else if (evtBelow) begin
        boostR   <= floorHit ? '0 : downVal;
        enAboveR <= 1'b1;
        if (floorHit) enBelowR <= 1'b0;
      end
    end
  end

  assign boost      = boostR;
  assign target     = targetR;
  assign targetDone = doneR;
  assign enAbove    = enAboveR;
  assign enBelow    = enBelowR;

  assert_ceiling_R3: assert property (@(posedge clk) disable iff (!rstN)
    (evtAbove && !restart) |=> (boost <= $past(maxFreq)));
  assert_arm_below_R2: assert property (@(posedge clk) disable iff (!rstN)
    (evtAbove && !restart) |=> enBelow);
  assert_floor_R5: assert property (@(posedge clk) disable iff (!rstN)
    (evtBelow && !evtAbove && !restart) |=> (enAbove && (boost == '0 || boost >= HALF)));
  assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    !enBelow |-> (boost == '0));
  assert_restart_R1: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> (boost == '0 && target == $past(curFreq) && enAbove && !enBelow && !targetDone));
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!evtAbove && !evtBelow && !restart) |=> ($stable(boost) && $stable(enAbove) && $stable(enBelow)));
endmodule

// File: rtl/boost_top.sv
module boost_top
  import boost_pkg::*;
#(
  parameter int W  = 32,
  parameter int CW = 16,
  parameter int PW = 9
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          restart,
  input  logic          evtAbove,
  input  logic          evtBelow,
  input  logic          calcReq,
  input  logic [W-1:0]  curFreq,
  input  logic [W-1:0]  avgCount,
  input  logic [PW-1:0] periodMs,
  input  logic [CW-1:0] upThresh,
  input  logic [CW-1:0] upCoeff,
  input  logic [CW-1:0] downCoeff,
  input  logic [W-1:0]  maxFreq,
  output logic [W-1:0]  boost,
  output logic [W-1:0]  target,
  output logic          targetDone,
  output logic          enAbove,
  output logic          enBelow
);
  ctrl_strobe_t strb;
  logic         divDone;
  logic         trigger;

  assign trigger = calcReq | evtAbove | evtBelow;

  boost_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .restart(restart), .trigger(trigger),
    .divDone(divDone), .strb(strb)
  );

  boost_dp #(.W(W), .CW(CW), .PW(PW)) u_dp (
    .clk(clk), .rstN(rstN), .restart(restart), .evtAbove(evtAbove), .evtBelow(evtBelow),
    .strb(strb), .curFreq(curFreq), .avgCount(avgCount), .periodMs(periodMs),
    .upThresh(upThresh), .upCoeff(upCoeff), .downCoeff(downCoeff), .maxFreq(maxFreq),
    .boost(boost), .target(target), .targetDone(targetDone),
    .enAbove(enAbove), .enBelow(enBelow), .divDone(divDone)
  );
endmodule

// File: tb/sim_boost_top.sv
module sim_boost_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        restart = 1'b0, evtAbove = 1'b0, evtBelow = 1'b0, calcReq = 1'b0;
  logic [31:0] curFreq = '0, avgCount = '0, maxFreq = 32'd1000000;
  logic [8:0]  periodMs = 9'd12;
  logic [15:0] upThresh = 16'd20, upCoeff = 16'd200, downCoeff = 16'd50;
  logic [31:0] boost, target;
  logic        targetDone, enAbove, enBelow;

  int checks = 0, failures = 0;
  logic [31:0] mB;
  logic        mEA, mEB;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  boost_top u0 (
    .clk(clk), .rstN(rstN), .restart(restart), .evtAbove(evtAbove), .evtBelow(evtBelow),
    .calcReq(calcReq), .curFreq(curFreq), .avgCount(avgCount), .periodMs(periodMs),
    .upThresh(upThresh), .upCoeff(upCoeff), .downCoeff(downCoeff), .maxFreq(maxFreq),
    .boost(boost), .target(target), .targetDone(targetDone), .enAbove(enAbove), .enBelow(enBelow)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pct(input logic [31:0] v, input logic [15:0] c);
    logic [63:0] p = (64'(v) * 64'(c)) / 64'd100;
    return (p > 64'hFFFFFFFF) ? 32'hFFFFFFFF : p[31:0];
  endfunction

  function automatic logic [31:0] expTgt(input logic [31:0] a, input logic [8:0] p,
                                         input logic [15:0] t, input logic [31:0] b);
    logic [63:0] r = ((64'(a) / 64'(p)) * (64'd10000 / 64'(t))) / 64'd100;
    logic [63:0] s;
    if (r > 64'hFFFFFFFF) r = 64'hFFFFFFFF;
    s = r + 64'(b);
    return (s > 64'hFFFFFFFF) ? 32'hFFFFFFFF : s[31:0];
  endfunction

  task automatic doRestart();
    @(negedge clk) restart = 1'b1;
    @(negedge clk) restart = 1'b0;
    mB = '0; mEA = 1'b1; mEB = 1'b0;
    chk("R1 restart boost", boost, 0);
    chk("R1 restart target", target, curFreq);
    chk("R1 restart enables", {enAbove, enBelow}, 2'b10);
  endtask

  task automatic evStep(input logic a, input logic b);
    string tag;
    logic [63:0] s;
    logic [31:0] d;
    @(negedge clk) begin evtAbove = a; evtBelow = b; end
    @(negedge clk) begin evtAbove = 1'b0; evtBelow = 1'b0; end
    if (a) begin
      s = 64'(pct(mB, upCoeff)) + 64'd16000;
      mEB = 1'b1;
      if (s >= 64'(maxFreq)) begin mB = maxFreq; mEA = 1'b0; tag = "R3 clamp"; end
      else begin mB = s[31:0]; tag = "R2 grow"; end
      if (b) tag = "R6 priority";
    end else if (b) begin
      d = pct(mB, downCoeff);
      mEA = 1'b1;
      if (d < 32'd8000) begin mB = '0; mEB = 1'b0; tag = "R5 floor"; end
      else begin mB = d; tag = "R4 decay"; end
    end else tag = "R10 hold";
    chk(tag, boost, mB);
    chk(tag, {enAbove, enBelow}, {mEA, mEB});
  endtask

  task automatic waitDone(output logic ok);
    ok = 1'b0;
    for (int i = 0; i < 400 && !ok; i++) begin
      @(negedge clk);
      if (targetDone) ok = 1'b1;
    end
  endtask

  task automatic runCalc(input logic [31:0] a, input logic [8:0] p, input logic [15:0] t);
    logic ok;
    repeat (300) @(negedge clk);
    avgCount = a; periodMs = p; upThresh = t;
    calcReq = 1'b1;
    @(negedge clk) calcReq = 1'b0;
    waitDone(ok);
    chk("R8 done pulse", ok, 1);
    chk("R8 target", target, expTgt(a, p, t, mB));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset boost", boost, 0);
    chk("R1 reset target", target, 0);
    chk("R1 reset enables", {enAbove, enBelow, targetDone}, 3'b100);
    rstN = 1'b1;

    // boost sweep over coefficient sets and ceilings
    for (int cfg = 0; cfg < 3; cfg++) begin
      for (int m = 0; m < 2; m++) begin
        case (cfg)
          0: begin upCoeff = 16'd200; downCoeff = 16'd50; end
          1: begin upCoeff = 16'd800; downCoeff = 16'd40; end
          default: begin upCoeff = 16'd250; downCoeff = 16'd300; end
        endcase
        maxFreq = (m == 0) ? 32'd1000000 : 32'hFFFFFFFF;
        curFreq = 32'd400000 + 32'(cfg * 1000 + m);
        doRestart();
        for (int k = 0; k < 40; k++) begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          evStep(lfsr[0], lfsr[1]);
        end
      end
    end

    // R7: drive boost to the all-ones ceiling, then decay with a coefficient above 100
    upCoeff = 16'd250; downCoeff = 16'd300; maxFreq = 32'hFFFFFFFF;
    doRestart();
    for (int k = 0; k < 40 && mEA; k++) evStep(1'b1, 1'b0);
    chk("R7 ceiling reached", boost, 32'hFFFFFFFF);
    evStep(1'b0, 1'b1);
    chk("R7 saturated product", boost, 32'hFFFFFFFF);

    // target arithmetic
    curFreq = 32'd12345;
    doRestart();
    runCalc(32'd1200000, 9'd12, 16'd20);
    runCalc(32'd7000, 9'd12, 16'd60);
    runCalc(32'd99999999, 9'd1, 16'd1);
    runCalc(32'd0, 9'd5, 16'd27);
    upCoeff = 16'd200; maxFreq = 32'd1000000;
    evStep(1'b1, 1'b0);
    evStep(1'b1, 1'b0);
    runCalc(32'd360000, 9'd12, 16'd27);

    // R9: a second request during a calculation reruns once with fresh inputs
    begin
      int dones = 0;
      logic [31:0] lastT = '0;
      repeat (300) @(negedge clk);
      avgCount = 32'd600000; periodMs = 9'd12; upThresh = 16'd20;
      calcReq = 1'b1;
      @(negedge clk) calcReq = 1'b0;
      repeat (10) @(negedge clk);
      avgCount = 32'd2400000;
      calcReq = 1'b1;
      @(negedge clk) calcReq = 1'b0;
      for (int i = 0; i < 400; i++) begin
        @(negedge clk);
        if (targetDone) begin dones++; lastT = target; end
      end
      chk("R9 rerun count", dones, 2);
      chk("R9 rerun target", lastT, expTgt(32'd2400000, 9'd12, 16'd20, mB));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule